// File: doc/BRIEF.md
# Software-Refilled Fully Associative Translation Buffer

This block turns a 32-bit virtual address into a physical address for 4 KB pages. It keeps a small table of page translations. Every incoming request is compared against all stored translations in the same cycle. When a stored translation matches, the block returns the physical page number joined to the untouched 12-bit byte offset. When nothing matches, the block records the virtual page number that failed and raises a one-cycle miss exception. System software then fills in the missing translation.

Entries are loaded only through a refill port that privileged software drives. Each fill writes one indexed slot with its tag, physical page, valid, dirty and write-permission bits. A write that hits an entry without write permission raises a one-cycle protection exception and does not complete. A permitted write that hits marks the entry dirty. An invalidate-all input empties the whole table in one cycle.

Top module: `sw_tlb`

## Requirements
- R1: When a request is valid and a valid entry's tag equals vaddr[31:12], `hit_o` is high in the same cycle and `paddr_o` equals that entry's physical page number (bits [31:12]) joined to vaddr[11:0] (bits [11:0]).
- R2: When a valid request matches no entry, `hit_o` is low and `paddr_o` is zero. In the next cycle `miss_exc_o` is high for exactly that one cycle, and `fault_vpn_o` holds vaddr[31:12] of the failed request until the next miss.
- R3: A fill with `fill_en_i` high writes the slot selected by `fill_idx_i` on the next rising edge, and lookups from the following cycle onward see all of its fields.
- R4: A write request that hits an entry with its write-permission bit clear still reports the hit. In the next cycle `prot_exc_o` is high for one cycle, and that entry's dirty bit stays unchanged.
- R5: A write request that hits an entry with write permission sets that entry's dirty bit from the next cycle. `hit_dirty_o` reports the dirty bit of the matching entry during any hit.
- R6: Read requests and requests that miss change no entry state. In particular, a clean entry stays clean after it is read.
- R7: After a synchronous active-low reset, every entry is invalid, both exceptions are low, and `fault_vpn_o` is zero.
- R8: `flush_i` clears every valid bit on the next edge. If a fill occurs in the same cycle, the flush wins, so the filled slot is also invalid.
- R9: When several valid entries match, the lowest-numbered entry supplies the translation and the dirty and permission bits.
- R10: An entry whose valid bit is clear never matches, even if its tag equals the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Translation request present |
| req_write_i | input | 1 | Request is a store |
| req_vaddr_i | input | 32 | Virtual address |
| hit_o | output | 1 | Request matched a valid entry (combinational) |
| paddr_o | output | 32 | Translated physical address, zero on miss |
| hit_dirty_o | output | 1 | Dirty bit of the matched entry |
| miss_exc_o | output | 1 | One-cycle miss exception, one cycle after the request |
| prot_exc_o | output | 1 | One-cycle write-protection exception, one cycle after the request |
| fault_vpn_o | output | 20 | Virtual page number of the most recent miss |
| fill_en_i | input | 1 | Software refill strobe |
| fill_idx_i | input | 6 | Slot to overwrite |
| fill_vpn_i | input | 20 | Virtual page tag to store |
| fill_ppn_i | input | 20 | Physical page number to store |
| fill_valid_i | input | 1 | Valid bit to store |
| fill_dirty_i | input | 1 | Dirty bit to store |
| fill_wperm_i | input | 1 | Write-permission bit to store |
| flush_i | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its default parameters: 64 slots, 20-bit page numbers and a 12-bit offset. This lets a fill index reach every slot, including slot 0 and slot 63, and it exercises the full priority encoder. Random tags are drawn from a pool of only 24 page numbers. As a result, duplicate tags in different slots occur often, so the lowest-index rule and refills over live entries get regular use. Directed cases add a flush and a fill in the same cycle, a permission fault, and a dirty bit that must survive reads.

// File: rtl/sw_tlb_pkg.sv
// Shared widths and the stored entry layout of the translation buffer.
// Assumes 4 KB pages, so the offset width fixes the page-number split.
package sw_tlb_pkg;
    parameter int VA_W  = 32;
    parameter int OFF_W = 12;
    parameter int VPN_W = VA_W - OFF_W;
    parameter int PPN_W = 20;
    parameter int PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             wperm;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/sw_tlb_store.sv
// Entry storage: one register slot per entry.
// A software fill overwrites a whole slot. A permitted store hit sets only
// the dirty bit. A flush clears every valid bit. If a fill and a dirty
// update target the same slot, the fill wins; a flush beats both.
module sw_tlb_store
    import sw_tlb_pkg::*;
#(
    parameter int  ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic                      fill_en_i,
    input  logic [IDX_W-1:0]          fill_idx_i,
    input  tlb_entry_t                fill_entry_i,
    input  logic                      dirty_set_i,
    input  logic [IDX_W-1:0]          dirty_idx_i,
    output tlb_entry_t [ENTRIES-1:0]  entries_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_entry_t slot_q;

        // Update one slot: reset, fill, dirty marking, then flush override.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                if (fill_en_i && (fill_idx_i == IDX_W'(g))) begin
                    slot_q <= fill_entry_i;
                end else if (dirty_set_i && (dirty_idx_i == IDX_W'(g))) begin
                    slot_q.dirty <= 1'b1;
                end
                if (flush_i) begin
                    slot_q.valid <= 1'b0;
                end
            end
        end

        assign entries_o[g] = slot_q;
    end
endmodule

// File: rtl/sw_tlb_match.sv
// Parallel tag comparison across all entries, then a priority pick.
// When several valid entries match, the lowest index is selected.
// Purely combinational.
module sw_tlb_match
    import sw_tlb_pkg::*;
#(
    parameter int  ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  tlb_entry_t [ENTRIES-1:0] entries_i,
    input  logic [VPN_W-1:0]         vpn_i,
    output logic [ENTRIES-1:0]       hit_vec_o,
    output logic                     any_hit_o,
    output logic [IDX_W-1:0]         hit_idx_o,
    output tlb_entry_t               hit_entry_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Compare one stored tag against the request.
        assign hit_vec_o[g] = entries_i[g].valid && (entries_i[g].vpn == vpn_i);
    end

    // Priority encode: scan from the top down so the lowest index wins.
    always_comb begin
        hit_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
        end
    end

    assign any_hit_o   = |hit_vec_o;
    assign hit_entry_o = entries_i[hit_idx_o];
endmodule

// File: rtl/sw_tlb_exc.sv
// Exception logic. Classifies each request as a miss, a protection fault
// or a permitted store. Registers the exceptions as one-cycle pulses and
// latches the faulting page number on a miss.
module sw_tlb_exc
    import sw_tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             hit_i,
    input  logic             wperm_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic             dirty_set_o,
    output logic             miss_exc_o,
    output logic             prot_exc_o,
    output logic [VPN_W-1:0] fault_vpn_o
);
    logic miss_now, prot_now;

    // Classify the current request.
    always_comb begin
        miss_now    = req_valid_i && !hit_i;
        prot_now    = req_valid_i && req_write_i && hit_i && !wperm_i;
        dirty_set_o = req_valid_i && req_write_i && hit_i && wperm_i;
    end

    // Register the exception pulses and the faulting page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_exc_o  <= 1'b0;
            prot_exc_o  <= 1'b0;
            fault_vpn_o <= '0;
        end else begin
            miss_exc_o <= miss_now;
            prot_exc_o <= prot_now;
            if (miss_now) fault_vpn_o <= vpn_i;
        end
    end
endmodule

// File: rtl/sw_tlb.sv
// Top level of the software-refilled, fully associative translation buffer.
// Lookup is combinational in the request cycle; exceptions follow one cycle
// later. Refill is driven only by software through the fill port.
module sw_tlb
    import sw_tlb_pkg::*;
#(
    parameter int  ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    output logic             hit_o,
    output logic [PA_W-1:0]  paddr_o,
    output logic             hit_dirty_o,
    output logic             miss_exc_o,
    output logic             prot_exc_o,
    output logic [VPN_W-1:0] fault_vpn_o,
    input  logic             fill_en_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic             fill_valid_i,
    input  logic             fill_dirty_i,
    input  logic             fill_wperm_i,
    input  logic             flush_i
);
    tlb_entry_t [ENTRIES-1:0] entry_q;
    tlb_entry_t               fill_entry;
    tlb_entry_t               match_entry;
    logic [ENTRIES-1:0]       hit_vec;
    logic [IDX_W-1:0]         hit_idx;
    logic                     match_any;
    logic                     dirty_set;
    logic [VPN_W-1:0]         req_vpn;

    // Split the address and pack the refill fields.
    always_comb begin
        req_vpn          = req_vaddr_i[VA_W-1:OFF_W];
        fill_entry.valid = fill_valid_i;
        fill_entry.dirty = fill_dirty_i;
        fill_entry.wperm = fill_wperm_i;
        fill_entry.vpn   = fill_vpn_i;
        fill_entry.ppn   = fill_ppn_i;
    end

    sw_tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .fill_en_i    (fill_en_i),
        .fill_idx_i   (fill_idx_i),
        .fill_entry_i (fill_entry),
        .dirty_set_i  (dirty_set),
        .dirty_idx_i  (hit_idx),
        .entries_o    (entry_q)
    );

    sw_tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .entries_i   (entry_q),
        .vpn_i       (req_vpn),
        .hit_vec_o   (hit_vec),
        .any_hit_o   (match_any),
        .hit_idx_o   (hit_idx),
        .hit_entry_o (match_entry)
    );

    sw_tlb_exc u_exc (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .hit_i       (match_any),
        .wperm_i     (match_entry.wperm),
        .vpn_i       (req_vpn),
        .dirty_set_o (dirty_set),
        .miss_exc_o  (miss_exc_o),
        .prot_exc_o  (prot_exc_o),
        .fault_vpn_o (fault_vpn_o)
    );

    // Drive the translation outputs; the address is zero when there is no hit.
    always_comb begin
        hit_o       = req_valid_i && match_any;
        hit_dirty_o = hit_o && match_entry.dirty;
        paddr_o     = hit_o ? {match_entry.ppn, req_vaddr_i[OFF_W-1:0]} : '0;
    end
endmodule

// File: rtl/sw_tlb_chk.sv
// Protocol checker for sw_tlb. It is attached to the top module by the
// bind statement at the end of this file.
module sw_tlb_chk
    import sw_tlb_pkg::*;
#(
    parameter int  ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid_i,
    input logic                     req_write_i,
    input logic [VA_W-1:0]          req_vaddr_i,
    input logic                     hit_o,
    input logic [PA_W-1:0]          paddr_o,
    input logic                     miss_exc_o,
    input logic                     prot_exc_o,
    input logic [VPN_W-1:0]         fault_vpn_o,
    input logic                     flush_i,
    input tlb_entry_t [ENTRIES-1:0] entries,
    input logic [ENTRIES-1:0]       hit_vec,
    input logic [IDX_W-1:0]         hit_idx
);
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] below_mask;

    // Gather the valid bits and the mask of indices below the winner.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) valid_vec[i] = entries[i].valid;
        below_mask = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);
    end

    // R2
    miss_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid_i && !hit_o) |-> miss_exc_o);

    // R2
    miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_exc_o |-> $past(req_valid_i && !hit_o));

    // R2
    fault_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_exc_o |-> (fault_vpn_o == $past(req_vaddr_i[VA_W-1:OFF_W])));

    // R4
    prot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_exc_o |-> $past(req_valid_i && req_write_i && hit_o));

    // R4
    exc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_exc_o && prot_exc_o));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (paddr_o[OFF_W-1:0] == req_vaddr_i[OFF_W-1:0]));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(flush_i) |-> (valid_vec == '0));

    // R9
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hit_vec[hit_idx] && ((hit_vec & below_mask) == '0)));
endmodule

bind sw_tlb sw_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_vaddr_i (req_vaddr_i),
    .hit_o       (hit_o),
    .paddr_o     (paddr_o),
    .miss_exc_o  (miss_exc_o),
    .prot_exc_o  (prot_exc_o),
    .fault_vpn_o (fault_vpn_o),
    .flush_i     (flush_i),
    .entries     (entry_q),
    .hit_vec     (hit_vec),
    .hit_idx     (hit_idx)
);

// File: tb/sim_sw_tlb.sv
// Self-checking bench: directed corners followed by seeded random traffic,
// compared against a reference table kept in the bench.
module sim_sw_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int NE         = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_vaddr;
    logic        hit_o, hit_dirty_o, miss_exc_o, prot_exc_o;
    logic [31:0] paddr_o;
    logic [19:0] fault_vpn_o;
    logic        fill_en, fill_valid, fill_dirty, fill_wperm, flush;
    logic [5:0]  fill_idx;
    logic [19:0] fill_vpn, fill_ppn;

    int n_vec = 0;
    int n_bad = 0;

    logic [19:0] m_vpn [NE];
    logic [19:0] m_ppn [NE];
    logic        m_val [NE];
    logic        m_dirty [NE];
    logic        m_wp [NE];
    logic [19:0] m_fault;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sw_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_vaddr_i(req_vaddr),
        .hit_o(hit_o), .paddr_o(paddr_o), .hit_dirty_o(hit_dirty_o),
        .miss_exc_o(miss_exc_o), .prot_exc_o(prot_exc_o), .fault_vpn_o(fault_vpn_o),
        .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_vpn_i(fill_vpn),
        .fill_ppn_i(fill_ppn), .fill_valid_i(fill_valid), .fill_dirty_i(fill_dirty),
        .fill_wperm_i(fill_wperm), .flush_i(flush)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_find(input logic [19:0] v);
        for (int i = 0; i < NE; i++) if (m_val[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    // One request: check lookup in its cycle, then the exceptions a cycle later.
    task automatic op_req(input string tag, input logic w, input logic [31:0] a);
        int idx;
        logic ex_miss, ex_prot;
        @(negedge clk);
        chk("R2", "idle miss pulse", {63'd0, miss_exc_o}, 64'd0);
        chk("R4", "idle prot pulse", {63'd0, prot_exc_o}, 64'd0);
        req_valid = 1'b1; req_write = w; req_vaddr = a;
        #1;
        idx = model_find(a[31:12]);
        chk(tag, "hit", {63'd0, hit_o}, {63'd0, idx >= 0});
        chk(tag, "paddr", {32'd0, paddr_o},
            idx >= 0 ? {32'd0, m_ppn[idx], a[11:0]} : 64'd0);
        chk("R5", "hit_dirty", {63'd0, hit_dirty_o},
            {63'd0, (idx >= 0) ? m_dirty[idx] : 1'b0});
        ex_miss = (idx < 0);
        ex_prot = w && (idx >= 0) && !m_wp[idx];
        if (w && idx >= 0 && m_wp[idx]) m_dirty[idx] = 1'b1;
        if (ex_miss) m_fault = a[31:12];
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R2", "miss_exc", {63'd0, miss_exc_o}, {63'd0, ex_miss});
        chk("R4", "prot_exc", {63'd0, prot_exc_o}, {63'd0, ex_prot});
        chk("R2", "fault_vpn", {44'd0, fault_vpn_o}, {44'd0, m_fault});
    endtask

    task automatic do_fill(input int i, input logic [19:0] v, input logic [19:0] p,
                           input logic vl, input logic d, input logic wp, input logic fl);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 6'(i); fill_vpn = v; fill_ppn = p;
        fill_valid = vl; fill_dirty = d; fill_wperm = wp; flush = fl;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
        m_vpn[i] = v; m_ppn[i] = p; m_val[i] = vl; m_dirty[i] = d; m_wp[i] = wp;
        if (fl) for (int k = 0; k < NE; k++) m_val[k] = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int k = 0; k < NE; k++) m_val[k] = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20071));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
        fill_en = 1'b0; fill_idx = '0; fill_vpn = '0; fill_ppn = '0;
        fill_valid = 1'b0; fill_dirty = 1'b0; fill_wperm = 1'b0; flush = 1'b0;
        m_fault = '0;
        for (int k = 0; k < NE; k++) begin
            m_vpn[k] = '0; m_ppn[k] = '0; m_val[k] = 1'b0; m_dirty[k] = 1'b0; m_wp[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk("R7", "miss_exc after reset", {63'd0, miss_exc_o}, 64'd0);
        chk("R7", "prot_exc after reset", {63'd0, prot_exc_o}, 64'd0);
        chk("R7", "fault_vpn after reset", {44'd0, fault_vpn_o}, 64'd0);
        op_req("R7", 1'b0, 32'h0000_0123);

        // R3, R1: fill a slot and translate through it
        do_fill(5, 20'h12345, 20'hABCDE, 1'b1, 1'b0, 1'b1, 1'b0);
        op_req("R1", 1'b0, 32'h1234_5678);
        op_req("R3", 1'b0, 32'h1234_5FFF);
        // R6: a read keeps the entry clean
        op_req("R6", 1'b0, 32'h1234_5000);
        // R5: permitted write marks dirty
        op_req("R5", 1'b1, 32'h1234_5010);
        op_req("R5", 1'b0, 32'h1234_5020);

        // R4: write to a read-only page faults and leaves dirty clear
        do_fill(9, 20'h00777, 20'h0F0F0, 1'b1, 1'b0, 1'b0, 1'b0);
        op_req("R4", 1'b1, 32'h0077_7ABC);
        op_req("R4", 1'b0, 32'h0077_7ABC);

        // R9: duplicates, lowest slot wins; then slots 0 and 63
        do_fill(20, 20'h55555, 20'h22222, 1'b1, 1'b0, 1'b1, 1'b0);
        do_fill(3, 20'h55555, 20'h33333, 1'b1, 1'b1, 1'b1, 1'b0);
        op_req("R9", 1'b0, 32'h5555_5004);
        do_fill(63, 20'hFFFFF, 20'h00001, 1'b1, 1'b0, 1'b1, 1'b0);
        do_fill(0, 20'hFFFFF, 20'h00002, 1'b1, 1'b0, 1'b1, 1'b0);
        op_req("R9", 1'b0, 32'hFFFF_F001);

        // R10: invalidated slot no longer matches, the next duplicate takes over
        do_fill(3, 20'h55555, 20'h33333, 1'b0, 1'b0, 1'b1, 1'b0);
        op_req("R10", 1'b0, 32'h5555_5008);
        do_fill(20, 20'h55555, 20'h22222, 1'b0, 1'b0, 1'b1, 1'b0);
        op_req("R10", 1'b0, 32'h5555_5008);

        // R8: flush empties the table; flush beats a same-cycle fill
        do_flush();
        op_req("R8", 1'b0, 32'h1234_5678);
        op_req("R8", 1'b0, 32'hFFFF_F001);
        do_fill(7, 20'h0ABCD, 20'h11111, 1'b1, 1'b0, 1'b1, 1'b1);
        op_req("R8", 1'b0, 32'h0ABC_D123);

        // Random traffic on a small tag pool
        for (int it = 0; it < 2000; it++) begin
            int r;
            logic [19:0] v;
            r = int'($urandom % 100);
            v = 20'h3C000 | 20'($urandom % 24);
            if (r < 28) begin
                do_fill(int'($urandom % NE), v, 20'($urandom), ($urandom % 8) != 0,
                        1'($urandom), 1'($urandom), 1'b0);
            end else if (r < 30) begin
                do_flush();
            end else begin
                int idx;
                idx = model_find(v);
                op_req(idx >= 0 ? "R1" : "R2", 1'($urandom), {v, 12'($urandom)});
            end
        end

        summary();
        $finish;
    end
endmodule